// File: doc/BRIEF.md
# I2C Bus Controller

This block is a byte-at-a-time I2C controller that a processor runs through four byte-wide registers. As bus master it generates START, repeated START and STOP conditions, shifts address and data bytes out or in, samples or returns the acknowledge bit, and detects loss of arbitration. As a slave it recognises its own 7-bit address after a START from another master. It acknowledges the address and reports the read/write bit. Every completed byte, every address match and every lost arbitration raises a pending flag, and that flag can drive an interrupt request.

Software sets enable, interrupt enable, direction and the acknowledge value in the control register. Setting the master bit starts a transfer with a START. Clearing it ends the transfer with a STOP. Writing the data register in transmit mode sends a byte. Reading it in receive mode clocks in the next byte. Between bytes the controller holds SCL low until software acts. The SCL rate comes from a programmable divider on the system clock. SCL and SDA are open-drain: an output of 1 pulls the line low.

Top module: `i2cc_top`

## Requirements
- R1: While control bit 0 (enable) is 0, neither line is pulled low, no START is generated even when the master bit is written, data register writes are ignored (the data register still reads 0 after enabling), and status reads 0.
- R2: The interrupt request equals status bit 5 (event pending) ANDed with control bit 1 (interrupt enable) and enable. Writing 1 to status bit 5 clears it.
- R3: Writing control bit 2 (master) from 0 to 1 on an idle bus generates a START: SDA falls while SCL is high, then SCL is held low. Status bit 2 (bus busy) becomes 1.
- R4: Clearing control bit 2 while the master waits between bytes generates a STOP: SDA rises while SCL is high. Both lines are then released, and the bus-busy bit returns to 0.
- R5: A data write (address 2) with control bit 3 (transmit) set sends the byte MSB first over 8 SCL pulses and releases SDA for the 9th. The 9th sampled SDA level is stored in status bit 6. Status bit 0 (byte done) and bit 5 are then set.
- R6: In master receive mode (control bit 3 = 0), reading address 2 starts the next byte. After completion, address 2 returns the 8 received bits, MSB first. In the 9th slot the master drives SDA to the value of control bit 4: 0 pulls SDA low (acknowledge), 1 leaves it released.
- R7: Writing 1 to control bit 5 while master and waiting between bytes generates a repeated START. The bit always reads 0. Writing it at any other time sets status bit 3 (arbitration lost) and bit 5.
- R8: If the master releases SDA for a data bit but samples it low while SCL is high, it sets status bits 3 and 5, clears the master bit, and releases both lines without a STOP.
- R9: When not master, after a START the controller samples 8 bits. If the upper 7 match OWN_ADDR, it pulls SDA low for the 9th slot and sets status bit 1 (addressed), bit 4 (equal to the received R/W bit) and bit 5. A mismatch gives no acknowledge and bit 1 stays 0.
- R10: Within a byte, the SCL period is 4 × (divider + 1) system clocks, where the divider is written at address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 control, 1 status, 2 data, 3 divider |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Read strobe (a data read in receive mode starts a byte) |
| rdAddr | input | 2 | Read address |
| rdData | output | 8 | Read data, combinational from rdAddr |
| irq | output | 1 | Interrupt request |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sclOe | output | 1 | Pull SCL low when 1 |
| sdaOe | output | 1 | Pull SDA low when 1 |

## Verification
The bench builds the controller with a divider of 3, giving a 16-clock SCL period, and OWN_ADDR 0x3A. This slow setting keeps every line change far from the two-register input synchroniser. It allows all 256 byte values to be sent and all 256 to be received within one transfer each. The acknowledge from the modelled slave follows a fixed index pattern, and the master's acknowledge alternates, so both acknowledge values are met in both directions. The bench also drives the bus directly as a second master, to force an arbitration loss and to address the block as a slave with a matching and a mismatching address.

// File: rtl/i2cc_pkg.sv
package i2cc_pkg;
  localparam int BYTE_W = 8;

  // register addresses
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;
  localparam logic [1:0] A_DIV  = 2'd3;

  // control bits
  localparam int C_EN   = 0;
  localparam int C_IE   = 1;
  localparam int C_MST  = 2;
  localparam int C_TX   = 3;
  localparam int C_TXAK = 4;
  localparam int C_RSTA = 5;

  // status bits
  localparam int S_TCF  = 0;
  localparam int S_AAS  = 1;
  localparam int S_BUSY = 2;
  localparam int S_ARBL = 3;
  localparam int S_SRW  = 4;
  localparam int S_IF   = 5;
  localparam int S_RXAK = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_HOLD, ST_BIT, ST_STOP, ST_RST
  } seqState_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic load;
    logic shift;
    logic bitIn;
  } dpStrb_t;
endpackage

// File: rtl/i2cc_dp.sv
module i2cc_dp
  import i2cc_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR = 7'h3A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              en,
  input  dpStrb_t           strb,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              mstActive,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic [BYTE_W-1:0] shReg,
  output logic              sclS,
  output logic              sdaS,
  output logic              busy,
  output logic              startDet,
  output logic              stopDet,
  output logic              slvHit,
  output logic              slvRw,
  output logic              slvAckDrv
);
  localparam int CNT_W = $clog2(BYTE_W + 2);

  logic              sclP, sdaP, slvOn;
  logic [CNT_W-1:0]  slvCnt;
  logic [BYTE_W-1:0] slvSh;
  logic              sclRise, sclFall, addrMatch;

  assign startDet  = sclS && sclP && sdaP && !sdaS;
  assign stopDet   = sclS && sclP && !sdaP && sdaS;
  assign sclRise   = sclS && !sclP;
  assign sclFall   = !sclS && sclP;
  assign addrMatch = (slvSh[BYTE_W-1:1] == OWN_ADDR);
  assign slvRw     = slvSh[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {sclS, sdaS, sclP, sdaP, busy, slvOn, slvAckDrv, slvHit} <= '0;
      slvCnt <= '0;
      slvSh  <= '0;
      shReg  <= '0;
    end else if (!en) begin
      {sclS, sdaS, sclP, sdaP, busy, slvOn, slvAckDrv, slvHit} <= '0;
      slvCnt <= '0;
      slvSh  <= '0;
      shReg  <= '0;
    end else begin
      sclS   <= sclIn;
      sdaS   <= sdaIn;
      sclP   <= sclS;
      sdaP   <= sdaS;
      slvHit <= 1'b0;
      if (startDet)     busy <= 1'b1;
      else if (stopDet) busy <= 1'b0;

      if (strb.load)       shReg <= wrData;
      else if (strb.shift) shReg <= {shReg[BYTE_W-2:0], strb.bitIn};

      if (startDet && !mstActive) begin
        slvOn     <= 1'b1;
        slvCnt    <= '0;
        slvAckDrv <= 1'b0;
      end else if (stopDet) begin
        slvOn     <= 1'b0;
        slvAckDrv <= 1'b0;
      end else if (slvOn) begin
        if (sclRise && slvCnt < CNT_W'(BYTE_W)) begin
          slvSh  <= {slvSh[BYTE_W-2:0], sdaS};
          slvCnt <= slvCnt + 1'b1;
        end else if (sclFall && slvCnt == CNT_W'(BYTE_W)) begin
          if (addrMatch) begin
            slvAckDrv <= 1'b1;
            slvHit    <= 1'b1;
            slvCnt    <= slvCnt + 1'b1;
          end else begin
            slvOn <= 1'b0;
          end
        end else if (sclFall && slvCnt == CNT_W'(BYTE_W + 1)) begin
          slvAckDrv <= 1'b0;
          slvOn     <= 1'b0;
        end
      end
    end
  end

  AST_SLV_ACK_NOT_MASTER: assert property (@(posedge clk) disable iff (!rstN) slvAckDrv |-> !mstActive); // R9
endmodule

// File: rtl/i2cc_ctrl.sv
module i2cc_ctrl
  import i2cc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [1:0]        rdAddr,
  output logic [BYTE_W-1:0] rdData,
  output logic              irq,
  input  logic              sclS,
  input  logic              sdaS,
  input  logic              busy,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              slvHit,
  input  logic              slvRw,
  input  logic [BYTE_W-1:0] shReg,
  output dpStrb_t           strb,
  output logic              enR,
  output logic              mstActive,
  output logic              mSclLow,
  output logic              mSdaLow
);
  localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

  seqState_t         st;
  logic              ieR, mstR, txR, txakR;
  logic              tcf, aas, arbl, srw, iif, rxak;
  logic [BYTE_W-1:0] divR, divCnt;
  logic [1:0]        ph;
  logic [3:0]        bitCnt;
  logic              tick, ctrlWr, statWr, dataWr, dataRd, rstaReq, rstaOk, drvLow;

  assign tick    = enR && (divCnt == '0);
  assign ctrlWr  = wrEn && wrAddr == A_CTRL;
  assign statWr  = wrEn && wrAddr == A_STAT;
  assign dataWr  = wrEn && wrAddr == A_DATA && enR;
  assign dataRd  = rdEn && rdAddr == A_DATA && enR;
  assign rstaReq = ctrlWr && wrData[C_RSTA];
  assign rstaOk  = rstaReq && st == ST_HOLD && mstR && wrData[C_MST];
  assign drvLow  = (bitCnt == LAST_BIT) ? (!txR && !txakR) : (txR && !shReg[BYTE_W-1]);

  assign mstActive   = (st != ST_IDLE);
  assign strb.load   = dataWr && st == ST_HOLD && txR && mstR;
  assign strb.shift  = st == ST_BIT && tick && ph == 2'd2 && sclS && bitCnt < LAST_BIT;
  assign strb.bitIn  = sdaS;
  assign irq         = enR && ieR && iif;

  always_comb begin
    unique case (rdAddr)
      A_CTRL:  rdData = {3'b000, txakR, txR, mstR, ieR, enR};
      A_STAT:  rdData = {1'b0, rxak, iif, srw, arbl, busy && enR, aas, tcf};
      A_DATA:  rdData = shReg;
      default: rdData = divR;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {enR, ieR, mstR, txR, txakR} <= '0;
      {tcf, aas, arbl, srw, iif, rxak} <= '0;
      {mSclLow, mSdaLow} <= '0;
      st <= ST_IDLE; ph <= '0; bitCnt <= '0;
      divR <= '0; divCnt <= '0;
    end else begin
      if (ctrlWr) {txakR, txR, mstR, ieR, enR} <= wrData[C_TXAK:C_EN];
      if (wrEn && wrAddr == A_DIV) divR <= wrData;
      if (!enR) begin
        {tcf, aas, arbl, srw, iif, rxak} <= '0;
        {mSclLow, mSdaLow} <= '0;
        st <= ST_IDLE; ph <= '0; divCnt <= '0;
      end else begin
        divCnt <= tick ? divR : divCnt - 1'b1;
        if (statWr && wrData[S_ARBL]) arbl <= 1'b0;
        if (statWr && wrData[S_IF])   iif  <= 1'b0;
        if (slvHit) begin
          aas <= 1'b1; srw <= slvRw; iif <= 1'b1;
        end else if (startDet || stopDet) aas <= 1'b0;
        if (dataWr || dataRd) tcf <= 1'b0;
        if (rstaReq && !rstaOk) begin arbl <= 1'b1; iif <= 1'b1; end
        unique case (st)
          ST_IDLE: begin
            ph <= '0; mSclLow <= 1'b0; mSdaLow <= 1'b0;
            if (mstR) begin
              if (busy) begin arbl <= 1'b1; iif <= 1'b1; mstR <= 1'b0; end
              else st <= ST_START;
            end
          end
          ST_START: if (tick) begin
            if (ph == 2'd0) begin mSdaLow <= 1'b1; ph <= 2'd1; end
            else begin mSclLow <= 1'b1; ph <= 2'd0; st <= ST_HOLD; end
          end
          ST_HOLD: begin
            ph <= '0;
            if (!mstR) st <= ST_STOP;
            else if (rstaOk) st <= ST_RST;
            else if ((dataWr && txR) || (dataRd && !txR)) begin
              st <= ST_BIT; bitCnt <= '0;
            end
          end
          ST_BIT: if (tick) begin
            unique case (ph)
              2'd0: begin mSdaLow <= drvLow; ph <= 2'd1; end
              2'd1: begin mSclLow <= 1'b0; ph <= 2'd2; end
              2'd2: if (sclS) begin
                ph <= 2'd3;
                if (bitCnt == LAST_BIT && txR) rxak <= sdaS;
                if (txR && bitCnt < LAST_BIT && !mSdaLow && !sdaS) begin
                  arbl <= 1'b1; iif <= 1'b1; mstR <= 1'b0;
                  mSdaLow <= 1'b0; mSclLow <= 1'b0; st <= ST_IDLE;
                end
              end
              default: begin
                mSclLow <= 1'b1; ph <= 2'd0;
                if (bitCnt == LAST_BIT) begin tcf <= 1'b1; iif <= 1'b1; st <= ST_HOLD; end
                else bitCnt <= bitCnt + 1'b1;
              end
            endcase
          end
          ST_STOP: if (tick) begin
            if (ph == 2'd0) begin mSdaLow <= 1'b1; ph <= 2'd1; end
            else if (ph == 2'd1) begin mSclLow <= 1'b0; ph <= 2'd2; end
            else if (sclS) begin mSdaLow <= 1'b0; ph <= 2'd0; st <= ST_IDLE; end
          end
          default: if (tick) begin
            if (ph == 2'd0) begin mSdaLow <= 1'b0; ph <= 2'd1; end
            else if (ph == 2'd1) begin mSclLow <= 1'b0; ph <= 2'd2; end
            else if (ph == 2'd2) begin if (sclS) begin mSdaLow <= 1'b1; ph <= 2'd3; end end
            else begin mSclLow <= 1'b1; ph <= 2'd0; st <= ST_HOLD; end
          end
        endcase
      end
    end
  end

  AST_START_SDA_FIRST: assert property (@(posedge clk) disable iff (!rstN) (st == ST_START && tick && ph == 2'd1) |-> mSdaLow); // R3
  AST_BITCNT_LIMIT: assert property (@(posedge clk) disable iff (!rstN) bitCnt <= LAST_BIT); // R5
  AST_TCF_IN_HOLD: assert property (@(posedge clk) disable iff (!rstN) $rose(tcf) |-> st == ST_HOLD); // R5
  AST_ARB_RELEASE: assert property (@(posedge clk) disable iff (!rstN) ($past(st) == ST_BIT && st == ST_IDLE && enR && $past(enR)) |-> (!mstR && !mSclLow && !mSdaLow)); // R8
endmodule

// File: rtl/i2cc_top.sv
module i2cc_top
  import i2cc_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR = 7'h3A
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic       rdEn,
  input  logic [1:0] rdAddr,
  output logic [7:0] rdData,
  output logic       irq,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sclOe,
  output logic       sdaOe
);
  dpStrb_t           strb;
  logic              en, mstActive, mSclLow, mSdaLow;
  logic              sclS, sdaS, busy, startDet, stopDet, slvHit, slvRw, slvAckDrv;
  logic [BYTE_W-1:0] shReg;

  i2cc_ctrl u_ctrl (
    .clk, .rstN, .wrEn, .wrAddr, .wrData, .rdEn, .rdAddr, .rdData, .irq,
    .sclS, .sdaS, .busy, .startDet, .stopDet, .slvHit, .slvRw, .shReg,
    .strb, .enR(en), .mstActive, .mSclLow, .mSdaLow
  );

  i2cc_dp #(.OWN_ADDR(OWN_ADDR)) u_dp (
    .clk, .rstN, .en, .strb, .wrData, .mstActive, .sclIn, .sdaIn,
    .shReg, .sclS, .sdaS, .busy, .startDet, .stopDet, .slvHit, .slvRw, .slvAckDrv
  );

  assign sclOe = en && mSclLow;
  assign sdaOe = en && (mSdaLow || slvAckDrv);
endmodule

// File: tb/sim_i2cc_top.sv
module sim_i2cc_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 3;
  localparam logic [6:0] OWN = 7'h3A;
  localparam logic [7:0] EN = 8'h01, IE = 8'h02, MST = 8'h04, TX = 8'h08, TXAK = 8'h10, RSTA = 8'h20;

  logic clk = 1'b0, rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       wrEn = 1'b0, rdEn = 1'b0;
  logic [1:0] wrAddr = '0, rdAddr = '0;
  logic [7:0] wrData = '0, rdData;
  logic       irq, sclOe, sdaOe;
  logic       extSclLow = 1'b0, extSdaLow = 1'b0, mdlSdaLow = 1'b0;
  wire        sclBus = !(sclOe || extSclLow);
  wire        sdaBus = !(sdaOe || extSdaLow || mdlSdaLow);

  i2cc_top #(.OWN_ADDR(OWN)) u0 (
    .clk, .rstN, .wrEn, .wrAddr, .wrData, .rdEn, .rdAddr, .rdData, .irq,
    .sclIn(sclBus), .sdaIn(sdaBus), .sclOe, .sdaOe
  );

  int vecs = 0, errs = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bus monitor and modelled slave
  int posCnt = 0, startCnt = 0, stopCnt = 0, slot = 0, nslot = 0, nbyte = 0;
  int arbSlot = -1, rxCount = 0, lastPeriod = 0;
  longint cyc = 0, lastRise = 0;
  logic [7:0] curByte = '0, lastByte = '0;
  logic lastAck = 1'b0;
  bit modelOn = 1, rxBytes = 0;

  function automatic logic [7:0] rxVal(input int n);
    return 8'((n * 73 + 5) & 255);
  endfunction
  function automatic bit ackLow(input int n);
    return (n % 3) != 2;
  endfunction

  always @(posedge clk) cyc++;
  always @(negedge sdaBus) if (sclBus) begin startCnt++; posCnt = 0; end
  always @(posedge sdaBus) if (sclBus) stopCnt++;
  always @(posedge sclBus) begin
    slot = posCnt % 9;
    if (slot < 8) curByte = {curByte[6:0], sdaBus};
    else begin lastByte = curByte; lastAck = sdaBus; end
    if (slot >= 1 && slot <= 7) lastPeriod = int'(cyc - lastRise);
    lastRise = cyc;
    posCnt++;
  end
  always @(negedge sclBus) if (modelOn) begin
    nslot = posCnt % 9;
    nbyte = posCnt / 9;
    mdlSdaLow = 1'b0;
    if (nbyte == 0) begin
      if (nslot == 8 || nslot == arbSlot) mdlSdaLow = 1'b1;
    end else if (rxBytes) begin
      if (nslot < 8 && nbyte - 1 < rxCount) mdlSdaLow = !rxVal(nbyte - 1)[7 - nslot];
    end else if (nslot == 8) mdlSdaLow = ackLow(nbyte - 1);
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask
  task automatic rdPulse(input logic [1:0] a);
    @(negedge clk); rdEn = 1'b1; rdAddr = a;
    @(negedge clk); rdEn = 1'b0;
  endtask
  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rdAddr = a; #1; d = rdData;
  endtask
  task automatic waitIf();
    logic [7:0] s;
    for (int i = 0; i < 4000; i++) begin
      peek(2'd1, s);
      if (s[5]) return;
    end
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic bangAddr(input logic [7:0] b, output logic ack);
    extSdaLow = 1'b1; idle(20); extSclLow = 1'b1; idle(20);
    for (int i = 7; i >= 0; i--) begin
      extSdaLow = !b[i]; idle(20); extSclLow = 1'b0; idle(20); extSclLow = 1'b1; idle(20);
    end
    extSdaLow = 1'b0; idle(20); extSclLow = 1'b0; idle(10);
    ack = sdaBus; idle(10); extSclLow = 1'b1; idle(20);
  endtask
  task automatic bangStop();
    extSdaLow = 1'b1; idle(20); extSclLow = 1'b0; idle(20); extSdaLow = 1'b0; idle(20);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    vecs++; errs++;
    $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
    finishRun();
  end

  initial begin
    logic [7:0] d;
    logic ack;
    int sc, sp;
    idle(5); rstN = 1'b1; idle(2);
    // reset state
    peek(2'd0, d); chk(d == 8'h00, "reset ctrl", d, 0);
    peek(2'd1, d); chk(d == 8'h00, "reset status", d, 0);
    chk(!sclOe && !sdaOe && !irq, "reset lines", {sclOe, sdaOe, irq}, 0);
    wr(2'd3, 8'(DIV));
    // R1 disabled block ignores requests
    wr(2'd0, MST); wr(2'd2, 8'h55); idle(100);
    chk(!sclOe && !sdaOe && startCnt == 0, "R1 lines while off", {sclOe, sdaOe}, 0);
    wr(2'd0, EN | IE);
    peek(2'd2, d); chk(d == 8'h00, "R1 data write ignored", d, 0);
    peek(2'd1, d); chk(d == 8'h00, "R1 status", d, 0);
    // R3 start
    wr(2'd0, EN | IE | MST | TX); idle(40);
    chk(startCnt == 1, "R3 start seen", startCnt, 1);
    peek(2'd1, d); chk(d[2], "R3 busy", d, 8'h04);
    chk(sclOe, "R3 scl held", sclOe, 1);
    // R5 address
    rxBytes = 0;
    wr(2'd2, 8'hA0); waitIf();
    chk(lastByte == 8'hA0, "R5 address bits", lastByte, 8'hA0);
    peek(2'd1, d); chk(d[6] == 1'b0 && d[0], "R5 address ack", d, 8'h21);
    chk(irq, "R2 irq raised", irq, 1);
    wr(2'd1, 8'h20);
    peek(2'd1, d); chk(!d[5] && !irq, "R2 flag cleared", {d[5], irq}, 0);
    // R5 sweep of all byte values
    for (int v = 0; v < 256; v++) begin
      wr(2'd2, 8'(v)); waitIf();
      chk(lastByte == 8'(v), "R5 data bits", lastByte, v);
      peek(2'd1, d);
      chk(d[0] && d[6] == !ackLow(v), "R5 ack status", d, {1'b0, !ackLow(v), 6'h20} | 8'h01);
      wr(2'd1, 8'h20);
    end
    chk(lastPeriod == 4 * (DIV + 1), "R10 scl period", lastPeriod, 4 * (DIV + 1));
    // R2 gating by interrupt enable
    wr(2'd0, EN | MST | TX); wr(2'd2, 8'h3C); waitIf();
    chk(!irq, "R2 irq masked", irq, 0);
    wr(2'd0, EN | IE | MST | TX); idle(1);
    chk(irq, "R2 irq unmasked", irq, 1);
    wr(2'd1, 8'h20);
    // R7 repeated start
    sc = startCnt;
    rxBytes = 1; rxCount = 256;
    wr(2'd0, EN | IE | MST | TX | RSTA); idle(40);
    chk(startCnt == sc + 1, "R7 repeated start", startCnt, sc + 1);
    peek(2'd0, d); chk(!d[5] && d[2], "R7 rsta reads 0", d, 8'h0F);
    peek(2'd1, d); chk(!d[3], "R7 legal no arbl", d, 0);
    // R6 receive sweep
    wr(2'd2, 8'hA1); waitIf(); wr(2'd1, 8'h20);
    for (int k = 0; k < 256; k++) begin
      wr(2'd0, EN | IE | MST | ((k & 1) ? TXAK : 8'h00));
      rdPulse(2'd2); waitIf();
      peek(2'd2, d); chk(d == rxVal(k), "R6 received byte", d, rxVal(k));
      chk(lastAck == 1'((k & 1)), "R6 ack driven", lastAck, k & 1);
      wr(2'd1, 8'h20);
    end
    // R4 stop
    sp = stopCnt;
    wr(2'd0, EN | IE); idle(60);
    chk(stopCnt == sp + 1, "R4 stop seen", stopCnt, sp + 1);
    peek(2'd1, d); chk(!d[2], "R4 bus free", d, 0);
    chk(!sclOe && !sdaOe, "R4 lines released", {sclOe, sdaOe}, 0);
    // R7 misplaced repeated start
    wr(2'd0, EN | IE | RSTA);
    peek(2'd1, d); chk(d[3] && d[5], "R7 illegal rsta", d, 8'h28);
    wr(2'd1, 8'h28);
    peek(2'd1, d); chk(!d[3] && !d[5], "R7 arbl cleared", d, 0);
    // R8 arbitration loss
    rxBytes = 0; arbSlot = 3;
    wr(2'd0, EN | IE | MST | TX); idle(40);
    sp = stopCnt;
    wr(2'd2, 8'hFF); waitIf();
    peek(2'd1, d); chk(d[3], "R8 arbl set", d, 8'h28);
    peek(2'd0, d); chk(!d[2], "R8 master dropped", d, 8'h0B);
    chk(!sclOe && !sdaOe, "R8 lines released", {sclOe, sdaOe}, 0);
    chk(stopCnt == sp, "R8 no stop", stopCnt, sp);
    arbSlot = -1; mdlSdaLow = 1'b0; idle(40);
    wr(2'd1, 8'h28);
    // R9 addressed as slave
    modelOn = 0;
    wr(2'd0, EN | IE);
    bangAddr({OWN, 1'b1}, ack);
    chk(ack == 1'b0, "R9 address acked", ack, 0);
    peek(2'd1, d); chk(d[1] && d[4] && d[5], "R9 aas srw", d, 8'h36);
    bangStop();
    wr(2'd1, 8'h20);
    bangAddr({OWN ^ 7'h01, 1'b0}, ack);
    chk(ack == 1'b1, "R9 mismatch no ack", ack, 1);
    peek(2'd1, d); chk(!d[1] && !d[5], "R9 mismatch flags", d, 0);
    bangStop();
    finishRun();
  end
endmodule